// File: doc/BRIEF.md
# Multiplexed converter host sequencer

This block is the host-side controller for an eight-input, 8-bit successive-approximation converter. The converter has an analog multiplexer and four control strobes: address latch, start, end-of-conversion and output enable. For each conversion the block puts a 3-bit input address on the converter's select lines, latches it, and pulses start. It then waits for end-of-conversion, enables the converter's outputs, and captures the 8-bit code. The code goes downstream together with the channel number on a valid/ready handshake. The block also produces the converter's clock from the system clock through a divider.

Three modes are selected by a 2-bit input. Single mode runs one conversion per request. Scan mode walks the inputs 0 through 7 and wraps for as long as the request is held. Free-running mode repeats conversions on one input: each completion leads straight to the next start without re-latching the address. A timeout flags a converter that never reports completion.

Top module: `adc_seq`

## Requirements
- R1: After reset, `resValid`, `aleOut`, `startOut`, `oeOut` and `timeoutErr` are all 0.
- R2: `convClk` is a square wave with a period of 2*DIV_HALF system clocks.
- R3: In single mode (`mode`=0, and also 3) a one-cycle `go` pulse drives `chanReq` onto `chanAddr`. The address is then latched with `aleOut` and `startOut` high together for one converter clock. `aleOut` is never high without `startOut`.
- R4: After start, the block waits until end-of-conversion is seen low before it accepts the high level. A completion flag still high from the previous conversion is therefore never taken as the new result.
- R5: `oeOut` rises only once end-of-conversion is high. The code read while `oeOut` is high is delivered on `resData`, with the latched input number on `resChan`.
- R6: While `resValid` is high and `resReady` is low, `resValid`, `resData` and `resChan` hold steady, and no new start is issued.
- R7: In scan mode (`mode`=1), held `go` converts inputs 0,1,…,7 and then wraps to 0. When `go` is low, the block stops after the result in flight is accepted.
- R8: In free-running mode (`mode`=2), held `go` repeats conversions on the requested input. Only the first start carries `aleOut`; every later start is issued without it.
- R9: If end-of-conversion does not go high within TIMEOUT_TICKS converter clocks of start, `timeoutErr` is set, no result is produced, and the block returns to idle. The flag clears when the next request starts.
- R10: In single mode exactly one conversion and one result follow each `go` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 single, 1 scan, 2 free-running, 3 single |
| go | input | 1 | Request (pulse in single, level in scan/free) |
| chanReq | input | 3 | Input number for single and free-running |
| convClk | output | 1 | Divided clock for the converter |
| chanAddr | output | 3 | Converter input select lines |
| aleOut | output | 1 | Address latch strobe |
| startOut | output | 1 | Conversion start strobe |
| eocIn | input | 1 | End-of-conversion from the converter |
| oeOut | output | 1 | Converter output enable |
| adcData | input | 8 | Converter data bus |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Downstream accepts result |
| resData | output | 8 | Captured code |
| resChan | output | 3 | Input number of the code |
| timeoutErr | output | 1 | Converter did not complete in time |

## Verification
Two conditions are hard to reach from the ports: a stale completion flag and a converter that never completes. Neither can happen with a well-behaved converter. The bench's behavioural converter has two knobs for them. One holds end-of-conversion high for several converter clocks after start, and the check is that the delivered code is the fresh one. The other stops completion altogether, and the check is that the error flag is raised with no result. A clean conversion follows to show that the flag clears. Backpressure during scan is made by a repeating ready pattern, so results wait in the output stage while the converter model counts any start that would overlap them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_SCAN   = 2'd1;
  localparam logic [1:0] MODE_FREE   = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_PULSE, ST_WLOW, ST_WHIGH, ST_READ, ST_SEND
  } seqState_t;

  typedef struct packed {
    logic loadReq;
    logic loadZero;
    logic incChan;
    logic capture;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int DIV_HALF = 98,
  parameter int DATA_W   = 8,
  parameter int CHAN_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [CHAN_W-1:0] chanReq,
  input  logic              eocRaw,
  input  logic [DATA_W-1:0] adcData,
  output logic              tick,
  output logic              eocSync,
  output logic              convClk,
  output logic [CHAN_W-1:0] chanAddr,
  output logic [DATA_W-1:0] resData,
  output logic [CHAN_W-1:0] resChan
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] divCnt;
  logic          eocMeta;
  logic [CHAN_W-1:0] chanReg;

  // converter clock divider; tick marks each rising edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      convClk <= 1'b0;
    end else if (divCnt == LAST) begin
      divCnt  <= '0;
      convClk <= ~convClk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
  assign tick = (divCnt == LAST) && !convClk;

  // two-flop synchronizer on the completion line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eocMeta <= 1'b0;
      eocSync <= 1'b0;
    end else begin
      eocMeta <= eocRaw;
      eocSync <= eocMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              chanReg <= '0;
    else if (strb.loadZero) chanReg <= '0;
    else if (strb.loadReq)  chanReg <= chanReq;
    else if (strb.incChan)  chanReg <= chanReg + 1'b1;
  end
  assign chanAddr = chanReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      resChan <= '0;
    end else if (strb.capture) begin
      resData <= adcData;
      resChan <= chanReg;
    end
  end

  // R2
  divider_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> convClk);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       go,
  input  logic       tick,
  input  logic       eocSync,
  input  logic       resReady,
  output seqStrobe_t strb,
  output logic       aleOut,
  output logic       startOut,
  output logic       oeOut,
  output logic       resValid,
  output logic       timeoutErr
);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_TICKS - 1);

  seqState_t   st;
  logic        latchAddr;
  logic [TW-1:0] timer;
  logic        isScan, isFree;

  assign isScan = (mode == MODE_SCAN);
  assign isFree = (mode == MODE_FREE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      latchAddr  <= 1'b0;
      timer      <= '0;
      timeoutErr <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          latchAddr  <= 1'b1;
          timeoutErr <= 1'b0;
          st         <= ST_SETUP;
        end
        ST_SETUP: if (tick) st <= ST_PULSE;
        ST_PULSE: if (tick) begin
          timer <= '0;
          st    <= ST_WLOW;
        end
        ST_WLOW, ST_WHIGH: if (tick) begin
          timer <= timer + 1'b1;
          if (st == ST_WLOW && !eocSync)      st <= ST_WHIGH;
          else if (st == ST_WHIGH && eocSync) st <= ST_READ;
          else if (timer == TLAST) begin
            timeoutErr <= 1'b1;
            st         <= ST_IDLE;
          end
        end
        ST_READ: if (tick) st <= ST_SEND;
        ST_SEND: if (resReady) begin
          if (go && isScan) begin
            latchAddr <= 1'b1;
            st        <= ST_SETUP;
          end else if (go && isFree) begin
            latchAddr <= 1'b0;
            st        <= ST_SETUP;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadReq  = (st == ST_IDLE) && go && !isScan;
    strb.loadZero = (st == ST_IDLE) && go && isScan;
    strb.incChan  = (st == ST_SEND) && resReady && go && isScan;
    strb.capture  = (st == ST_READ) && tick;
  end

  assign startOut = (st == ST_PULSE);
  assign aleOut   = (st == ST_PULSE) && latchAddr;
  assign oeOut    = (st == ST_READ);
  assign resValid = (st == ST_SEND);

  // R5
  oe_after_eoc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeOut) |-> eocSync);
  // R9
  err_no_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> !resValid);
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int DIV_HALF      = 98,
  parameter int TIMEOUT_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       go,
  input  logic [2:0] chanReq,
  output logic       convClk,
  output logic [2:0] chanAddr,
  output logic       aleOut,
  output logic       startOut,
  input  logic       eocIn,
  output logic       oeOut,
  input  logic [7:0] adcData,
  output logic       resValid,
  input  logic       resReady,
  output logic [7:0] resData,
  output logic [2:0] resChan,
  output logic       timeoutErr
);
  seqStrobe_t strb;
  logic tick, eocSync;

  adc_seq_ctrl #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_ctrl (
    .clk, .rstN, .mode, .go, .tick, .eocSync, .resReady,
    .strb, .aleOut, .startOut, .oeOut, .resValid, .timeoutErr
  );

  adc_seq_dp #(.DIV_HALF(DIV_HALF), .DATA_W(8), .CHAN_W(3)) u_dp (
    .clk, .rstN, .strb, .chanReq, .eocRaw(eocIn), .adcData,
    .tick, .eocSync, .convClk, .chanAddr, .resData, .resChan
  );

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid && $stable(resData) && $stable(resChan));
  // R6
  no_start_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !startOut);
  // R3
  ale_with_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |-> startOut);
endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam int DIVH = 2;
  localparam int TMO  = 30;
  localparam int CONV = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic go = 1'b0;
  logic [2:0] chanReq = 3'd0;
  logic convClk, aleOut, startOut, oeOut, resValid, timeoutErr;
  logic [2:0] chanAddr, resChan;
  logic [7:0] resData;
  logic eocModel = 1'b1;
  logic [7:0] modelRes = 8'h00;
  logic resReady = 1'b1;
  logic [7:0] adcData;

  assign adcData = oeOut ? modelRes : 8'h00;

  adc_seq #(.DIV_HALF(DIVH), .TIMEOUT_TICKS(TMO)) u_adc_seq (
    .clk, .rstN, .mode, .go, .chanReq, .convClk, .chanAddr, .aleOut,
    .startOut, .eocIn(eocModel), .oeOut, .adcData, .resValid, .resReady,
    .resData, .resChan, .timeoutErr
  );

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  int cyc = 0;
  bit finished = 0;

  // converter model knobs and counters
  int staleTicks = 0;
  bit hang = 0;
  bit busy = 0;
  int phase = 0, convLeft = 0, seqNo = 0;
  logic [2:0] latched = 3'd0;
  int starts = 0, aleStarts = 0, startsPending = 0;
  int riseCyc[$];
  logic [10:0] expQ[$];
  int accCnt = 0;
  logic [2:0] accChan[256];
  bit backpress = 0;
  logic prevConv = 1'b0, pV = 1'b0, pR = 1'b0;
  logic [7:0] pD = 8'h00;
  logic [2:0] pC = 3'd0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(posedge clk);
    #2;
    resReady <= backpress ? ((cyc % 5) >= 3) : 1'b1;
  end

  // behavioural converter plus cycle-by-cycle output checks
  always @(negedge clk) begin
    if (rstN) begin
      if (convClk && !prevConv) begin
        riseCyc.push_back(cyc);
        if (startOut) begin
          starts++;
          if (resValid) startsPending++;
          if (aleOut) begin
            latched = chanAddr;
            aleStarts++;
          end
          busy = 1;
          phase = staleTicks;
          convLeft = CONV;
          if (phase == 0) eocModel = 1'b0;
        end else if (busy) begin
          if (phase > 0) begin
            phase--;
            if (phase == 0) eocModel = 1'b0;
          end else if (!hang) begin
            convLeft--;
            if (convLeft == 0) begin
              busy = 0;
              seqNo++;
              modelRes = 8'(latched * 37 + seqNo * 11 + 5);
              eocModel = 1'b1;
              expQ.push_back({latched, modelRes});
            end
          end
        end
      end
      // R6 hold while stalled
      if (pV && !pR)
        chk(resValid && resData == pD && resChan == pC, "R6 hold",
            int'({resValid, resData, resChan}), int'({1'b1, pD, pC}));
      if (resValid && resReady) begin
        if (expQ.size() == 0) chk(0, "R5 unexpected result", int'(resData), -1);
        else begin
          logic [10:0] e;
          e = expQ.pop_front();
          chk({resChan, resData} == e, "R5 result", int'({resChan, resData}), int'(e));
        end
        accChan[accCnt % 256] = resChan;
        accCnt++;
      end
      pV = resValid; pR = resReady; pD = resData; pC = resChan;
    end
    prevConv = convClk;
  end

  task automatic waitAcc(input int target, input string tag);
    int n = 0;
    while (accCnt < target && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(accCnt >= target, tag, accCnt, target);
  endtask

  task automatic pulseGo(input logic [1:0] m, input logic [2:0] c);
    @(negedge clk);
    mode = m; chanReq = c; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic idleWait(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int base, s0, a0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk({resValid, aleOut, startOut, oeOut, timeoutErr} == 5'b0, "R1 reset",
        int'({resValid, aleOut, startOut, oeOut, timeoutErr}), 0);
    rstN = 1'b1;
    idleWait(40);
    // R2 divider period
    for (int i = 1; i < 5; i++)
      chk(riseCyc[i] - riseCyc[i-1] == 2 * DIVH, "R2 period",
          riseCyc[i] - riseCyc[i-1], 2 * DIVH);

    // R3 single conversion on input 5
    a0 = aleStarts; s0 = starts;
    pulseGo(2'd0, 3'd5);
    waitAcc(1, "R3 single done");
    chk(accChan[0] == 3'd5, "R3 channel", accChan[0], 5);
    chk(aleStarts - a0 == 1 && starts - s0 == 1, "R3 ale with start",
        aleStarts - a0, 1);
    // R10 no further activity
    idleWait(200);
    chk(accCnt == 1 && starts - s0 == 1, "R10 one per go", starts - s0, 1);
    pulseGo(2'd3, 3'd7);
    waitAcc(2, "R10 mode3 single");
    chk(accChan[1] == 3'd7, "R10 channel", accChan[1], 7);
    pulseGo(2'd0, 3'd0);
    waitAcc(3, "R3 input 0");
    chk(accChan[2] == 3'd0, "R3 channel0", accChan[2], 0);

    // R4 stale completion flag held high after start
    staleTicks = 3;
    pulseGo(2'd0, 3'd2);
    waitAcc(4, "R4 stale done");
    chk(accChan[3] == 3'd2 && expQ.size() == 0, "R4 fresh code", accChan[3], 2);
    staleTicks = 0;
    idleWait(50);

    // R7 scan with backpressure, R6 no start while pending
    base = accCnt;
    backpress = 1;
    @(negedge clk); mode = 2'd1; go = 1'b1;
    waitAcc(base + 10, "R7 scan count");
    go = 1'b0;
    idleWait(400);
    backpress = 0;
    for (int k = 0; k < 10; k++)
      chk(accChan[base + k] == 3'(k % 8), "R7 scan order", accChan[base + k], k % 8);
    chk(startsPending == 0, "R6 start while pending", startsPending, 0);
    chk(accCnt - base >= 10 && accCnt - base <= 11, "R7 stop", accCnt - base, 10);

    // R8 free-running on input 3
    base = accCnt; a0 = aleStarts; s0 = starts;
    @(negedge clk); mode = 2'd2; chanReq = 3'd3; go = 1'b1;
    waitAcc(base + 4, "R8 free count");
    go = 1'b0;
    idleWait(200);
    for (int k = 0; k < 4; k++)
      chk(accChan[base + k] == 3'd3, "R8 channel", accChan[base + k], 3);
    chk(aleStarts - a0 == 1, "R8 single latch", aleStarts - a0, 1);
    chk(starts - s0 >= 4, "R8 restarts", starts - s0, 4);

    // R9 converter never completes
    base = accCnt;
    hang = 1;
    pulseGo(2'd0, 3'd1);
    idleWait((TMO + 8) * 2 * DIVH);
    chk(timeoutErr == 1'b1, "R9 flag", timeoutErr, 1);
    chk(accCnt == base && !resValid, "R9 no result", accCnt - base, 0);
    hang = 0;
    pulseGo(2'd0, 3'd4);
    idleWait(2);
    chk(timeoutErr == 1'b0, "R9 clear", timeoutErr, 0);
    waitAcc(base + 1, "R9 recovery");
    chk(accChan[base] == 3'd4, "R9 recovery channel", accChan[base], 4);

    idleWait(20);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule